// File: doc/BRIEF.md
# Moving-Average Conversion-Element Driver

This block takes a one-bit sigma-delta audio stream, qualified by a bit-period enable, and spreads it across a fixed row of equally weighted conversion elements. A chain of flip-flops delays the stream. Every stage of the chain drives one element line, so each element carries the same stream, shifted by a different whole number of bit periods. Together the lines form a scrambled unary code. The number of lines at logic one is the moving sum of the last N stream bits. Different patterns with the same count stand for the same level. An external resistor network sums the lines into a current, so every stream bit is converted once by each element.

The block keeps a binary running count of the active lines alongside the element lines. This count is the PCM equivalent of the moving average and can be used in the digital domain. For a balanced analog stage, every element also has a complementary rail from its own flip-flop. That flip-flop is loaded on the same clock edge as the true rail. A synchronous reset empties the chain.

Top module: `dsd_elem_driver`

## Requirements
- R1: A synchronous reset, applied for one or more clock edges, gives elem_p all zeros, elem_n all ones and level zero. A reset takes priority over bit_en.
- R2: On a clock edge with bit_en high, elem_p[0] takes bit_in and elem_p[k] takes the previous elem_p[k-1] for k from 1 to N_ELEM-1. The bit that was in elem_p[N_ELEM-1] is discarded.
- R3: level is always equal to the number of ones on elem_p. It is an unsigned binary value with $clog2(N_ELEM+1) bits.
- R4: Between consecutive enabled bit periods, level changes by at most one. It never exceeds N_ELEM, so there are N_ELEM+1 distinct levels.
- R5: On a clock edge with bit_en low and no reset, elem_p, elem_n and level keep their values.
- R6: elem_n is always the bitwise complement of elem_p, and both rails update on the same clock edge.
- R7: After N_ELEM enabled ones, level is N_ELEM. Each later enabled zero lowers level by one, and level reaches zero after exactly N_ELEM zeros. In this way each input bit counts once in each of N_ELEM periods.
- R8: level is the same for any two histories that hold the same number of ones in the last N_ELEM enabled bits, whatever their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-period enable; the chain advances on edges where it is high |
| bit_in | input | 1 | Incoming sigma-delta stream bit |
| elem_p | output | N_ELEM | True element lines; bit 0 carries the newest bit |
| elem_n | output | N_ELEM | Complementary element lines for a balanced stage |
| level | output | $clog2(N_ELEM+1) | Binary count of active element lines |

## Verification
The bench builds the block with the default N_ELEM of 32, which gives a 6-bit count with 33 levels. With this value, a run of ones can reach full scale and show the top value of 32, and a full drain of 32 zeros can be watched step by step within a short run. Irregular enable gaps and random streams exercise the hold behaviour and show that patterns with equal counts give equal levels. A reset in mid-stream checks the return to the empty state.

// File: rtl/dsd_elem_pkg.sv
package dsd_elem_pkg;

  // Running-sum update: add the arriving bit, remove the departing bit.
  function automatic logic [15:0] sum_step(input logic [15:0] cur,
                                           input logic arrive,
                                           input logic depart);
    logic [15:0] t;
    t = cur;
    if (arrive && !depart) t = cur + 16'd1;
    else if (!arrive && depart) t = cur - 16'd1;
    return t;
  endfunction

  // Complementary rail value for a stage input.
  function automatic logic rail_n(input logic v);
    return ~v;
  endfunction

endpackage

// File: rtl/dsd_delay_line.sv
module dsd_delay_line #(
  parameter int N_ELEM = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              din,
  output logic [N_ELEM-1:0] taps,
  output logic [N_ELEM-1:0] taps_next,
  output logic              tail
);

  assign taps_next = {taps[N_ELEM-2:0], din};
  assign tail      = taps[N_ELEM-1];

  for (genvar s = 0; s < N_ELEM; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)      taps[s] <= 1'b0;
      else if (adv) taps[s] <= taps_next[s];
    end
  end

endmodule

// File: rtl/dsd_run_sum.sv
module dsd_run_sum
  import dsd_elem_pkg::*;
#(
  parameter int N_ELEM = 32,
  localparam int CW = $clog2(N_ELEM + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          arrive,
  input  logic          depart,
  output logic [CW-1:0] sum
);

  logic [15:0] wide_next;

  always_comb wide_next = sum_step(16'(sum), arrive, depart);

  always_ff @(posedge clk) begin
    if (rst)      sum <= '0;
    else if (adv) sum <= wide_next[CW-1:0];
  end

endmodule

// File: rtl/dsd_bal_rail.sv
module dsd_bal_rail
  import dsd_elem_pkg::*;
#(
  parameter int N_ELEM = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [N_ELEM-1:0] nxt,
  output logic [N_ELEM-1:0] q_n
);

  for (genvar s = 0; s < N_ELEM; s++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst)      q_n[s] <= 1'b1;
      else if (adv) q_n[s] <= rail_n(nxt[s]);
    end
  end

endmodule

// File: rtl/dsd_elem_driver.sv
module dsd_elem_driver #(
  parameter int N_ELEM = 32,
  localparam int CW = $clog2(N_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [N_ELEM-1:0] elem_p,
  output logic [N_ELEM-1:0] elem_n,
  output logic [CW-1:0]     level
);

  // Named internal events, visible to the checker
  logic              adv;
  logic              exit_bit;
  logic [N_ELEM-1:0] chain_next;

  assign adv = bit_en;

  dsd_delay_line #(.N_ELEM(N_ELEM)) u_line (
    .clk(clk), .rst(rst), .adv(adv), .din(bit_in),
    .taps(elem_p), .taps_next(chain_next), .tail(exit_bit)
  );

  dsd_run_sum #(.N_ELEM(N_ELEM)) u_sum (
    .clk(clk), .rst(rst), .adv(adv),
    .arrive(bit_in), .depart(exit_bit), .sum(level)
  );

  dsd_bal_rail #(.N_ELEM(N_ELEM)) u_rail (
    .clk(clk), .rst(rst), .adv(adv), .nxt(chain_next), .q_n(elem_n)
  );

endmodule

// File: rtl/dsd_elem_driver_chk.sv
module dsd_elem_driver_chk #(
  parameter int N_ELEM = 32,
  localparam int CW = $clog2(N_ELEM + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              bit_in,
  input logic [N_ELEM-1:0] elem_p,
  input logic [N_ELEM-1:0] elem_n,
  input logic [CW-1:0]     level
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (elem_p == '0) && (elem_n == '1) && (level == '0));

  a_r2_shift: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> (elem_p[0] == $past(bit_in)) &&
               (elem_p[N_ELEM-1:1] == $past(elem_p[N_ELEM-2:0])));

  a_r3_level_popcount: assert property (@(posedge clk) disable iff (rst)
    int'(level) == $countones(elem_p));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> (level == $past(level)) ||
               (level == $past(level) + CW'(1)) ||
               ($past(level) == level + CW'(1)));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= N_ELEM);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(elem_p) && $stable(elem_n) && $stable(level));

  a_r6_complement: assert property (@(posedge clk) disable iff (rst)
    elem_n == ~elem_p);

endmodule

bind dsd_elem_driver dsd_elem_driver_chk #(.N_ELEM(N_ELEM)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
  .elem_p(elem_p), .elem_n(elem_n), .level(level)
);

// File: tb/sim_dsd_elem_driver.sv
module sim_dsd_elem_driver;
  localparam int N = 32;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic [N-1:0] elem_p, elem_n;
  logic [CW-1:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model: history of accepted bits, newest first
  int hist[$];
  int prev_level = 0;

  always #2 clk = ~clk;

  dsd_elem_driver #(.N_ELEM(N)) u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .elem_p(elem_p), .elem_n(elem_n), .level(level)
  );

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_count();
    int c = 0;
    foreach (hist[i]) c += hist[i];
    return c;
  endfunction

  // One clock: drive inputs, let the edge pass, update model, compare
  task automatic cyc(input logic r, input logic en, input logic b);
    logic [N-1:0] exp_p;
    int cnt, d;
    rst = r; bit_en = en; bit_in = b;
    @(posedge clk);
    if (r) hist.delete();
    else if (en) begin
      hist.push_front(int'(b));
      if (hist.size() > N) void'(hist.pop_back());
    end
    #1;
    exp_p = '0;
    foreach (hist[i]) exp_p[i] = hist[i][0];
    cnt = model_count();
    chk("R2 elem_p", elem_p == exp_p, longint'(elem_p), longint'(exp_p));
    chk("R6 elem_n", elem_n == ~exp_p, longint'(elem_n), longint'(~exp_p));
    chk("R3 level", int'(level) == cnt, longint'(level), longint'(cnt));
    if (!r && en) begin
      d = int'(level) - prev_level;
      chk("R4 step", d >= -1 && d <= 1, longint'(d), 0);
    end
    if (!r && !en)
      chk("R5 hold", int'(level) == prev_level, longint'(level), longint'(prev_level));
    prev_level = int'(level);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lvl_a, lvl_b;
    // R1: reset state
    cyc(1, 0, 0);
    cyc(1, 1, 1);
    chk("R1 reset", elem_p == '0 && elem_n == '1 && level == '0, longint'(level), 0);

    // R7: fill with ones, then drain
    for (int i = 0; i < N; i++) cyc(0, 1, 1);
    chk("R7 full", int'(level) == N, longint'(level), N);
    cyc(0, 1, 1);
    chk("R4 ceiling", int'(level) == N, longint'(level), N);
    for (int i = 0; i < N; i++) begin
      cyc(0, 1, 0);
      chk("R7 drain", int'(level) == N - 1 - i, longint'(level), N - 1 - i);
    end

    // R5: gaps between enables
    for (int i = 0; i < 40; i++) cyc(0, (i % 3) == 0, i[1]);
    cyc(0, 1, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, ~bit_in);

    // R8: two orderings with equal counts
    cyc(1, 0, 0);
    for (int i = 0; i < N; i++) cyc(0, 1, i < 12);
    lvl_a = int'(level);
    cyc(1, 0, 0);
    for (int i = 0; i < N; i++) cyc(0, 1, (i % 8) < 3);
    lvl_b = int'(level);
    chk("R8 order", lvl_a == 12 && lvl_b == 12, longint'(lvl_b), longint'(lvl_a));

    // Alternating and random streams
    for (int i = 0; i < 80; i++) cyc(0, 1, i[0]);
    for (int i = 0; i < 2000; i++) cyc(0, ($urandom % 4) != 0, $urandom % 2);

    // R1: reset mid-stream, priority over enable
    cyc(1, 1, 1);
    chk("R1 midreset", level == '0 && elem_p == '0, longint'(level), 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule